// File: doc/BRIEF.md
# Data Bus Occupancy Timer

This block tracks when a shared data bus can take its next transfer. A client asks for a transfer by giving a byte count, the index of the thread it serves and the port to answer. The block works out how many bus cycles the payload needs at the configured bus width and holds the bus busy for that long. It sends a one-cycle delivery pulse to the requesting port on the clock after the start. Arrival order of the words within the payload is left to the receiver.

A second, simpler path handles address acknowledgements. Each acknowledgement takes exactly one bus cycle, so one can be accepted on every clock, and each produces its own delivery pulse one clock later. For both paths the block keeps per-thread saturating statistics: how many requests started, and the total time each request waited between the time stamp it carries and its start. It also keeps a saturating total of the cycles each bus sat free before a start. The time stamps come from a free-running cycle counter that the block exports, so clients stamp requests from the same time base. Arbitration and payload storage belong to the surrounding logic.

Top module: `occ_bus_timer`

## Requirements
- R1: A data transfer of S bytes occupies N = ceil(S / BUS_BYTES) cycles, with a zero-byte transfer counted as one cycle. The start cycle is the first of these. `data_busy` is high for the N-1 cycles that follow, and a new request is accepted in the cycle N after the start. This holds for power-of-two and other bus widths.
- R2: A data request presented while `data_busy` is high is dropped. No delivery pulse follows, no statistic changes and the busy period ends as before. `data_overlap` is high for one cycle on the following clock.
- R3: An accepted data request gives `data_dlv_valid` high for exactly one cycle, on the clock after the start, with `data_dlv_port` equal to the requesting port. Back-to-back single-cycle transfers give one pulse per cycle.
- R4: At each data start, the number of cycles the data bus sat free since it last became free is added to the data idle total. That count is zero when the start comes in the first free cycle. Before the first start it is counted from reset.
- R5: Each accepted data request adds one to the data request count of its thread and to no other thread.
- R6: Each accepted data request adds `time_now - data_req_origin` to the data queue-delay total of its thread. `time_now` is sampled in the cycle the request is presented.
- R7: An address acknowledgement is accepted in every cycle it is presented, including on consecutive cycles. `addr_dlv_valid` follows for one cycle on the next clock with the acknowledged port. The per-thread address count and delay totals follow the same rules as R5 and R6.
- R8: At each address acknowledgement, the number of preceding cycles without an acknowledgement since the previous one is added to the address idle total. Before the first acknowledgement it is counted from reset.
- R9: During reset, `time_now`, both busy and delivery outputs, `data_overlap` and every statistic read as zero.
- R10: Every statistic saturates at 2^STAT_W-1 and stays there.
- R11: `time_now` starts at 0 after reset and increases by one on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_req_valid | input | 1 | Data transfer request in this cycle |
| data_req_size | input | SIZE_W | Payload size in bytes |
| data_req_thread | input | THR_W | Thread the request is counted against |
| data_req_port | input | PORT_W | Port to receive the delivery pulse |
| data_req_origin | input | 32 | `time_now` value when the request was first raised |
| addr_req_valid | input | 1 | Address acknowledgement in this cycle |
| addr_req_thread | input | THR_W | Thread of the acknowledgement |
| addr_req_port | input | PORT_W | Port to receive the address delivery pulse |
| addr_req_origin | input | 32 | `time_now` value when the address request was raised |
| time_now | output | 32 | Free-running bus cycle counter |
| data_busy | output | 1 | Data bus occupied by a transfer started earlier |
| data_overlap | output | 1 | A request was dropped in the previous cycle |
| data_dlv_valid | output | 1 | Data delivery pulse |
| data_dlv_port | output | PORT_W | Port of the data delivery |
| addr_dlv_valid | output | 1 | Address delivery pulse |
| addr_dlv_port | output | PORT_W | Port of the address delivery |
| stat_thread | input | THR_W | Thread whose statistics are shown |
| stat_data_reqs | output | STAT_W | Data requests of the selected thread |
| stat_data_delay | output | STAT_W | Data queue-delay total of the selected thread |
| stat_addr_reqs | output | STAT_W | Address acknowledgements of the selected thread |
| stat_addr_delay | output | STAT_W | Address queue-delay total of the selected thread |
| stat_data_idle | output | STAT_W | Total free data-bus cycles before starts |
| stat_addr_idle | output | STAT_W | Total cycles without acknowledgement before acknowledgements |

## Verification
Every byte count from zero to the largest size is swept on two instances, one with a width of four bytes and one with a width of three. Each busy period is measured against the ceiling quotient, so an off-by-one in the rounding or a missing zero clamp shows as a period one cycle too long or too short on some size. Idle gaps of zero to four cycles are produced on purpose, which catches a design that counts the start cycle itself or refuses a start in the first free cycle. A request is injected into a busy bus to show it leaves no delivery, no count and no longer busy period behind. Long runs of back-to-back requests and large delays drive the counters into their ceiling, where a design without saturation would wrap to small values.

// File: rtl/occ_pkg.sv
package occ_pkg;

    localparam int unsigned TIME_W = 32;

    typedef logic [TIME_W-1:0] occ_time_t;

    // index width for a count of items, at least one bit
    function automatic int unsigned occ_idx_w(int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/occ_ceil_div.sv
module occ_ceil_div #(
    parameter int unsigned SIZE_W    = 8,
    parameter int unsigned BUS_BYTES = 8
) (
    input  logic [SIZE_W-1:0] size_i,
    output logic [SIZE_W-1:0] cycles_o
);

    localparam int unsigned SH      = (BUS_BYTES > 1) ? $clog2(BUS_BYTES) : 0;
    localparam bit          IS_POW2 = (BUS_BYTES == (1 << SH));

    logic [SIZE_W-1:0] raw;

    generate
        if (BUS_BYTES == 1) begin : g_unit
            assign raw = size_i;
        end else if (IS_POW2) begin : g_shift
            logic [SIZE_W-1:0] quo;
            logic              rem_nz;
            assign quo    = size_i >> SH;
            assign rem_nz = |size_i[SH-1:0];
            assign raw    = quo + SIZE_W'(rem_nz);
        end else begin : g_div
            localparam int unsigned EW = SIZE_W + SH + 1;
            logic [EW-1:0] num;
            logic [EW-1:0] quo;
            assign num = EW'(size_i) + EW'(BUS_BYTES - 1);
            assign quo = num / EW'(BUS_BYTES);
            assign raw = quo[SIZE_W-1:0];
        end
    endgenerate

    // a zero-byte transfer still takes its start cycle
    assign cycles_o = (raw == '0) ? SIZE_W'(1) : raw;

    always_comb begin
        if (!$isunknown(size_i) && size_i != '0) begin
            p_ceil_bounds_r1: assert ((int'(cycles_o) * int'(BUS_BYTES) >= int'(size_i)) &&
                                      ((int'(cycles_o) - 1) * int'(BUS_BYTES) < int'(size_i)))
                else $error("occupancy is not the rounded-up quotient");
        end
    end

endmodule

// File: rtl/occ_data_timer.sv
module occ_data_timer
    import occ_pkg::*;
#(
    parameter int unsigned CYC_W  = 8,
    parameter int unsigned PORT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [CYC_W-1:0]  cycles_i,
    input  logic [PORT_W-1:0] port_i,
    output logic              start_o,
    output logic              busy_o,
    output logic              overlap_o,
    output logic              dlv_valid_o,
    output logic [PORT_W-1:0] dlv_port_o,
    output occ_time_t         idle_gap_o
);

    typedef struct packed {
        logic [CYC_W-1:0]  left;      // busy cycles still to come
        occ_time_t         idle_run;  // free cycles since bus went free
        logic              dlv;
        logic [PORT_W-1:0] dlv_port;
        logic              overlap;
    } dstate_t;

    dstate_t st_d, st_q;
    logic    start;

    always_comb begin
        st_d        = st_q;
        start       = req_i && (st_q.left == '0);
        st_d.dlv    = start;
        st_d.overlap = req_i && !start;
        if (start) begin
            st_d.left     = cycles_i - CYC_W'(1);
            st_d.dlv_port = port_i;
            st_d.idle_run = '0;
        end else if (st_q.left != '0) begin
            st_d.left = st_q.left - CYC_W'(1);
        end else if (st_q.idle_run != '1) begin
            st_d.idle_run = st_q.idle_run + TIME_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign start_o     = start;
    assign busy_o      = (st_q.left != '0);
    assign overlap_o   = st_q.overlap;
    assign dlv_valid_o = st_q.dlv;
    assign dlv_port_o  = st_q.dlv_port;
    assign idle_gap_o  = st_q.idle_run;

    p_countdown_r1: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (st_q.left == $past(st_q.left) - CYC_W'(1)));

    p_drop_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && req_i) |=> (!dlv_valid_o && overlap_o));

    p_dlv_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> (dlv_valid_o && dlv_port_o == $past(port_i)));

    p_idle_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (idle_gap_o == '0));

endmodule

// File: rtl/occ_addr_timer.sv
module occ_addr_timer
    import occ_pkg::*;
#(
    parameter int unsigned PORT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ack_i,
    input  logic [PORT_W-1:0] port_i,
    output logic              dlv_valid_o,
    output logic [PORT_W-1:0] dlv_port_o,
    output occ_time_t         idle_gap_o
);

    typedef struct packed {
        occ_time_t         idle_run;
        logic              dlv;
        logic [PORT_W-1:0] dlv_port;
    } astate_t;

    astate_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.dlv = ack_i;
        if (ack_i) begin
            st_d.dlv_port = port_i;
            st_d.idle_run = '0;
        end else if (st_q.idle_run != '1) begin
            st_d.idle_run = st_q.idle_run + TIME_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dlv_valid_o = st_q.dlv;
    assign dlv_port_o  = st_q.dlv_port;
    assign idle_gap_o  = st_q.idle_run;

    p_ack_dlv_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> (dlv_valid_o && dlv_port_o == $past(port_i)));

    p_no_ack_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_i |=> !dlv_valid_o);

    p_gap_grows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_i && idle_gap_o != '1) |=> (idle_gap_o == $past(idle_gap_o) + TIME_W'(1)));

endmodule

// File: rtl/occ_thread_stats.sv
module occ_thread_stats
    import occ_pkg::*;
#(
    parameter  int unsigned THREADS = 4,
    parameter  int unsigned STAT_W  = 32,
    localparam int unsigned THR_W   = occ_idx_w(THREADS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_i,
    input  logic [THR_W-1:0]  thread_i,
    input  occ_time_t         delay_i,
    input  occ_time_t         idle_i,
    input  logic [THR_W-1:0]  sel_i,
    output logic [STAT_W-1:0] count_o,
    output logic [STAT_W-1:0] delay_o,
    output logic [STAT_W-1:0] idle_o
);

    localparam int unsigned       AW   = ((STAT_W > TIME_W) ? STAT_W : TIME_W) + 1;
    localparam logic [STAT_W-1:0] SMAX = '1;

    typedef struct packed {
        logic [THREADS-1:0][STAT_W-1:0] cnt;
        logic [THREADS-1:0][STAT_W-1:0] dly;
        logic [STAT_W-1:0]              idle;
    } sstate_t;

    sstate_t st_d, st_q;

    function automatic logic [STAT_W-1:0] sat_add(logic [STAT_W-1:0] a, occ_time_t b);
        logic [AW-1:0] s;
        s = AW'(a) + AW'(b);
        return (s > AW'(SMAX)) ? SMAX : s[STAT_W-1:0];
    endfunction

    always_comb begin
        st_d = st_q;
        if (upd_i) begin
            for (int t = 0; t < THREADS; t++) begin
                if (thread_i == THR_W'(t)) begin
                    st_d.cnt[t] = sat_add(st_q.cnt[t], TIME_W'(1));
                    st_d.dly[t] = sat_add(st_q.dly[t], delay_i);
                end
            end
            st_d.idle = sat_add(st_q.idle, idle_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        count_o = '0;
        delay_o = '0;
        for (int t = 0; t < THREADS; t++) begin
            if (sel_i == THR_W'(t)) begin
                count_o = st_q.cnt[t];
                delay_o = st_q.dly[t];
            end
        end
    end

    assign idle_o = st_q.idle;

    generate
        for (genvar g = 0; g < THREADS; g++) begin : g_chk
            p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (upd_i && thread_i == THR_W'(g) && st_q.cnt[g] != SMAX)
                |=> (st_q.cnt[g] == $past(st_q.cnt[g]) + STAT_W'(1)));

            p_other_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
                !(upd_i && thread_i == THR_W'(g))
                |=> ($stable(st_q.cnt[g]) && $stable(st_q.dly[g])));

            p_ceiling_r10: assert property (@(posedge clk) disable iff (!rst_n)
                (st_q.cnt[g] == SMAX) |=> (st_q.cnt[g] == SMAX));

            p_delay_mono_r6: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> (st_q.dly[g] >= $past(st_q.dly[g])));
        end
    endgenerate

endmodule

// File: rtl/occ_bus_timer.sv
module occ_bus_timer
    import occ_pkg::*;
#(
    parameter  int unsigned BUS_BYTES = 8,
    parameter  int unsigned SIZE_W    = 8,
    parameter  int unsigned THREADS   = 4,
    parameter  int unsigned PORTS     = 4,
    parameter  int unsigned STAT_W    = 32,
    localparam int unsigned THR_W     = occ_idx_w(THREADS),
    localparam int unsigned PORT_W    = occ_idx_w(PORTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_req_valid,
    input  logic [SIZE_W-1:0] data_req_size,
    input  logic [THR_W-1:0]  data_req_thread,
    input  logic [PORT_W-1:0] data_req_port,
    input  logic [31:0]       data_req_origin,
    input  logic              addr_req_valid,
    input  logic [THR_W-1:0]  addr_req_thread,
    input  logic [PORT_W-1:0] addr_req_port,
    input  logic [31:0]       addr_req_origin,
    output logic [31:0]       time_now,
    output logic              data_busy,
    output logic              data_overlap,
    output logic              data_dlv_valid,
    output logic [PORT_W-1:0] data_dlv_port,
    output logic              addr_dlv_valid,
    output logic [PORT_W-1:0] addr_dlv_port,
    input  logic [THR_W-1:0]  stat_thread,
    output logic [STAT_W-1:0] stat_data_reqs,
    output logic [STAT_W-1:0] stat_data_delay,
    output logic [STAT_W-1:0] stat_addr_reqs,
    output logic [STAT_W-1:0] stat_addr_delay,
    output logic [STAT_W-1:0] stat_data_idle,
    output logic [STAT_W-1:0] stat_addr_idle
);

    typedef struct packed {
        occ_time_t now;
    } tstate_t;

    tstate_t ts_d, ts_q;

    always_comb begin
        ts_d     = ts_q;
        ts_d.now = ts_q.now + TIME_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ts_q <= '0;
        end else begin
            ts_q <= ts_d;
        end
    end

    assign time_now = ts_q.now;

    logic [SIZE_W-1:0] occ_cycles;
    logic              data_start;
    occ_time_t         data_gap;
    occ_time_t         addr_gap;
    occ_time_t         data_wait;
    occ_time_t         addr_wait;
    logic [STAT_W-1:0] addr_idle_unused_sink;

    assign data_wait = ts_q.now - data_req_origin;
    assign addr_wait = ts_q.now - addr_req_origin;

    occ_ceil_div #(
        .SIZE_W    (SIZE_W),
        .BUS_BYTES (BUS_BYTES)
    ) u_ceil (
        .size_i   (data_req_size),
        .cycles_o (occ_cycles)
    );

    occ_data_timer #(
        .CYC_W  (SIZE_W),
        .PORT_W (PORT_W)
    ) u_data (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (data_req_valid),
        .cycles_i    (occ_cycles),
        .port_i      (data_req_port),
        .start_o     (data_start),
        .busy_o      (data_busy),
        .overlap_o   (data_overlap),
        .dlv_valid_o (data_dlv_valid),
        .dlv_port_o  (data_dlv_port),
        .idle_gap_o  (data_gap)
    );

    occ_addr_timer #(
        .PORT_W (PORT_W)
    ) u_addr (
        .clk         (clk),
        .rst_n       (rst_n),
        .ack_i       (addr_req_valid),
        .port_i      (addr_req_port),
        .dlv_valid_o (addr_dlv_valid),
        .dlv_port_o  (addr_dlv_port),
        .idle_gap_o  (addr_gap)
    );

    occ_thread_stats #(
        .THREADS (THREADS),
        .STAT_W  (STAT_W)
    ) u_data_stats (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_i    (data_start),
        .thread_i (data_req_thread),
        .delay_i  (data_wait),
        .idle_i   (data_gap),
        .sel_i    (stat_thread),
        .count_o  (stat_data_reqs),
        .delay_o  (stat_data_delay),
        .idle_o   (stat_data_idle)
    );

    occ_thread_stats #(
        .THREADS (THREADS),
        .STAT_W  (STAT_W)
    ) u_addr_stats (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_i    (addr_req_valid),
        .thread_i (addr_req_thread),
        .delay_i  (addr_wait),
        .idle_i   (addr_gap),
        .sel_i    (stat_thread),
        .count_o  (stat_addr_reqs),
        .delay_o  (stat_addr_delay),
        .idle_o   (addr_idle_unused_sink)
    );

    assign stat_addr_idle = addr_idle_unused_sink;

    p_time_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (time_now == $past(time_now) + 32'd1));

    p_overlap_no_dlv_r2: assert property (@(posedge clk) disable iff (!rst_n)
        data_overlap |-> !data_dlv_valid);

endmodule

// File: tb/occ_bus_timer_tb.sv
module occ_bus_timer_tb_top;

    localparam int SIZE_W  = 6;
    localparam int THREADS = 4;
    localparam int PORTS   = 4;
    localparam int STAT_W  = 8;
    localparam int SMAX    = 255;

    logic        clk;
    logic        rst_n;
    logic        data_req_valid;
    logic [5:0]  data_req_size;
    logic [1:0]  data_req_thread;
    logic [1:0]  data_req_port;
    logic [31:0] data_req_origin;
    logic        addr_req_valid;
    logic [1:0]  addr_req_thread;
    logic [1:0]  addr_req_port;
    logic [31:0] addr_req_origin;
    logic [1:0]  stat_thread;

    logic [31:0] time_now;
    logic        data_busy, data_overlap, data_dlv_valid, addr_dlv_valid;
    logic [1:0]  data_dlv_port, addr_dlv_port;
    logic [7:0]  stat_data_reqs, stat_data_delay, stat_addr_reqs, stat_addr_delay;
    logic [7:0]  stat_data_idle, stat_addr_idle;

    logic [31:0] w3_time_now;
    logic        w3_busy, w3_overlap, w3_dlv_valid, w3_addr_dlv_valid;
    logic [1:0]  w3_dlv_port, w3_addr_dlv_port;
    logic [7:0]  w3_s0, w3_s1, w3_s2, w3_s3, w3_s4, w3_s5;

    int checks = 0;
    int errors = 0;

    initial clk = 1'b0;
    always #4 clk = ~clk;

    occ_bus_timer #(.BUS_BYTES(4), .SIZE_W(SIZE_W), .THREADS(THREADS),
                    .PORTS(PORTS), .STAT_W(STAT_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .data_req_valid(data_req_valid), .data_req_size(data_req_size),
        .data_req_thread(data_req_thread), .data_req_port(data_req_port),
        .data_req_origin(data_req_origin),
        .addr_req_valid(addr_req_valid), .addr_req_thread(addr_req_thread),
        .addr_req_port(addr_req_port), .addr_req_origin(addr_req_origin),
        .time_now(time_now), .data_busy(data_busy), .data_overlap(data_overlap),
        .data_dlv_valid(data_dlv_valid), .data_dlv_port(data_dlv_port),
        .addr_dlv_valid(addr_dlv_valid), .addr_dlv_port(addr_dlv_port),
        .stat_thread(stat_thread),
        .stat_data_reqs(stat_data_reqs), .stat_data_delay(stat_data_delay),
        .stat_addr_reqs(stat_addr_reqs), .stat_addr_delay(stat_addr_delay),
        .stat_data_idle(stat_data_idle), .stat_addr_idle(stat_addr_idle)
    );

    occ_bus_timer #(.BUS_BYTES(3), .SIZE_W(SIZE_W), .THREADS(THREADS),
                    .PORTS(PORTS), .STAT_W(STAT_W)) dut_w3_i (
        .clk(clk), .rst_n(rst_n),
        .data_req_valid(data_req_valid), .data_req_size(data_req_size),
        .data_req_thread(data_req_thread), .data_req_port(data_req_port),
        .data_req_origin(data_req_origin),
        .addr_req_valid(addr_req_valid), .addr_req_thread(addr_req_thread),
        .addr_req_port(addr_req_port), .addr_req_origin(addr_req_origin),
        .time_now(w3_time_now), .data_busy(w3_busy), .data_overlap(w3_overlap),
        .data_dlv_valid(w3_dlv_valid), .data_dlv_port(w3_dlv_port),
        .addr_dlv_valid(w3_addr_dlv_valid), .addr_dlv_port(w3_addr_dlv_port),
        .stat_thread(stat_thread),
        .stat_data_reqs(w3_s0), .stat_data_delay(w3_s1),
        .stat_addr_reqs(w3_s2), .stat_addr_delay(w3_s3),
        .stat_data_idle(w3_s4), .stat_addr_idle(w3_s5)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic sel(input int thr);
        stat_thread = 2'(thr);
        #1;
    endtask

    task automatic wait_free();
        while (data_busy || w3_busy) @(negedge clk);
    endtask

    function automatic int ceil_n(input int s, input int w);
        return (s == 0) ? 1 : (s + w - 1) / w;
    endfunction

    function automatic int sat(input int v);
        return (v > SMAX) ? SMAX : v;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int t0, i1, prev, c, q;
        int dly [8];
        dly = '{0, 1, 7, 30, 90, 90, 90, 5};
        rst_n = 1'b0;
        data_req_valid = 1'b0; data_req_size = '0; data_req_thread = '0;
        data_req_port = '0; data_req_origin = '0;
        addr_req_valid = 1'b0; addr_req_thread = '0; addr_req_port = '0;
        addr_req_origin = '0; stat_thread = '0;
        repeat (3) @(negedge clk);
        sel(0);
        // R9 reset state
        chk("R9 time", time_now, 0);
        chk("R9 busy", {31'd0, data_busy}, 0);
        chk("R9 dlv", {30'd0, data_dlv_valid, addr_dlv_valid}, 0);
        chk("R9 overlap", {31'd0, data_overlap}, 0);
        chk("R9 stats", {stat_data_reqs, stat_data_delay, stat_addr_reqs, stat_addr_delay}, 0);
        chk("R9 idle", {16'd0, stat_data_idle, stat_addr_idle}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R11 time after two clocks", time_now, 2);
        @(negedge clk);
        chk("R11 time step", time_now, 3);

        // R7/R8 address path
        t0 = int'(time_now);
        addr_req_valid = 1'b1; addr_req_thread = 2'd0; addr_req_port = 2'd1;
        addr_req_origin = time_now - 32'd5;
        @(negedge clk);
        addr_req_valid = 1'b0;
        sel(0);
        chk("R7 addr dlv", {30'd0, addr_dlv_valid, addr_dlv_port[0]}, 3);
        chk("R7 addr count", stat_addr_reqs, 1);
        chk("R7 addr delay", stat_addr_delay, 5);
        chk("R8 addr idle from reset", stat_addr_idle, 32'(t0));
        for (int i = 0; i < 3; i++) begin
            addr_req_valid = 1'b1; addr_req_thread = 2'(i + 1); addr_req_port = 2'(i);
            addr_req_origin = time_now - 32'(i);
            @(negedge clk);
            chk("R7 back-to-back dlv", {29'd0, addr_dlv_valid, addr_dlv_port}, 32'(4 + i));
        end
        addr_req_valid = 1'b0;
        for (int i = 0; i < 3; i++) begin
            sel(i + 1);
            chk("R7 addr count per thread", stat_addr_reqs, 1);
            chk("R7 addr delay per thread", stat_addr_delay, 32'(i));
        end
        chk("R8 no gap back-to-back", stat_addr_idle, 32'(t0));
        @(negedge clk);
        chk("R7 addr pulse single", {31'd0, addr_dlv_valid}, 0);
        repeat (2) @(negedge clk);
        addr_req_valid = 1'b1; addr_req_thread = 2'd0; addr_req_origin = time_now;
        @(negedge clk);
        addr_req_valid = 1'b0;
        chk("R8 addr gap of three", stat_addr_idle, 32'(t0 + 3));

        // R4 idle gaps on the data bus
        t0 = int'(time_now);
        for (int k = 0; k < 6; k++) begin
            data_req_valid = 1'b1; data_req_size = 6'd8; data_req_thread = 2'd2;
            data_req_port = 2'd0; data_req_origin = time_now;
            @(negedge clk);
            data_req_valid = 1'b0;
            i1 = int'(stat_data_idle);
            if (k == 0) chk("R4 idle counted from reset", 32'(i1), 32'(t0));
            else chk("R4 idle gap", 32'(i1 - prev), 32'(k - 1));
            prev = i1;
            repeat (1 + k) @(negedge clk);
        end

        // R2 request while busy
        wait_free();
        sel(1);
        c = int'(stat_data_reqs);
        data_req_valid = 1'b1; data_req_size = 6'd40; data_req_thread = 2'd0;
        data_req_port = 2'd2; data_req_origin = time_now;
        @(negedge clk);
        chk("R3 dlv port", {29'd0, data_dlv_valid, data_dlv_port}, 6);
        data_req_thread = 2'd1; data_req_port = 2'd3; data_req_size = 6'd4;
        @(negedge clk);
        data_req_valid = 1'b0;
        chk("R2 overlap flagged, no dlv", {30'd0, data_overlap, data_dlv_valid}, 2);
        repeat (7) @(negedge clk);
        chk("R2 busy end unchanged, still busy", {31'd0, data_busy}, 1);
        @(negedge clk);
        chk("R2 busy ends on time", {30'd0, data_busy, data_overlap}, 0);
        sel(1);
        chk("R2 dropped request not counted", stat_data_reqs, 32'(c));

        // R5/R6/R10 per-thread counts and delays
        wait_free();
        foreach (dly[j]) begin
            sel(3);
            c = int'(stat_data_reqs);
            q = int'(stat_data_delay);
            data_req_valid = 1'b1; data_req_size = 6'd1; data_req_thread = 2'd3;
            data_req_port = 2'd1; data_req_origin = time_now - 32'(dly[j]);
            @(negedge clk);
            data_req_valid = 1'b0;
            sel(3);
            chk("R5 data count", stat_data_reqs, 32'(c + 1));
            chk("R6 R10 data delay", stat_data_delay, 32'(sat(q + dly[j])));
        end
        sel(0);
        c = int'(stat_data_reqs);
        for (int i = 0; i < 260; i++) begin
            data_req_valid = 1'b1; data_req_size = 6'd3; data_req_thread = 2'd2;
            data_req_port = 2'(i); data_req_origin = time_now;
            @(negedge clk);
            if (i == 5) begin
                chk("R3 back-to-back pulse", {29'd0, data_dlv_valid, data_dlv_port}, 5);
                chk("R1 single-cycle not busy", {31'd0, data_busy}, 0);
            end
        end
        data_req_valid = 1'b0;
        @(negedge clk);
        sel(2);
        chk("R10 count saturates", stat_data_reqs, SMAX);
        sel(0);
        chk("R5 other thread untouched", stat_data_reqs, 32'(c));

        // R1/R3 size sweep on both widths
        wait_free();
        for (int s = 0; s < 64; s++) begin
            int b4, b3;
            data_req_valid = 1'b1; data_req_size = 6'(s); data_req_thread = 2'(s);
            data_req_port = 2'(s + 1); data_req_origin = time_now;
            @(negedge clk);
            data_req_valid = 1'b0;
            chk("R3 sweep dlv w4", {29'd0, data_dlv_valid, data_dlv_port}, 32'(4 + ((s + 1) % 4)));
            chk("R3 sweep dlv w3", {29'd0, w3_dlv_valid, w3_dlv_port}, 32'(4 + ((s + 1) % 4)));
            b4 = 0;
            b3 = 0;
            for (int k = 0; k < 80; k++) begin
                if (data_busy) b4++;
                if (w3_busy) b3++;
                if (!data_busy && !w3_busy) break;
                @(negedge clk);
                if (k == 0) chk("R3 pulse lasts one cycle", {30'd0, data_dlv_valid, w3_dlv_valid}, 0);
            end
            chk("R1 busy length width 4", 32'(b4), 32'(ceil_n(s, 4) - 1));
            chk("R1 busy length width 3", 32'(b3), 32'(ceil_n(s, 3) - 1));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule